// File: doc/BRIEF.md
# System Control Port Register File

This block sits on a byte-wide synchronous I/O port bus of a legacy system board. It decodes a small set of port addresses and holds the board's writable control state: a little-endian mode bit, a disk-activity light, a four-bit system control value, a map-type bit that selects how another block translates I/O addresses, and two byte-wide scratch ports. Reads of identification and status ports return fixed bytes. Writes to certain ports raise one-cycle strobes: a soft-reset request, two lock toggles for an external non-volatile memory, and a cache-invalidate pulse.

A host drives `port_addr` with `port_wr` or `port_rd` for one cycle. Write effects and strobes appear after the clock edge that samples the write. Read data is registered: it is valid in the cycle after `port_rd` and holds until the next read. A read in the same cycle as a write returns the state from before that write. Any address that is not decoded reads as 0xFF.

Top module: `sysport_regs`

## Requirements
- R1: After reset `endian_le`, `map_noncontig`, `disk_light`, all strobes and `port_rdata` are 0, and the control value reads back as 0x00.
- R2: A write to 0x092 sets `endian_le` to data bit 1 (1 means little-endian). A read of 0x092 returns 0x00. `endian_le` changes only on such a write.
- R3: A write to 0x092 with data bit 0 set raises `soft_rst_req` for exactly one cycle. With bit 0 clear it stays low.
- R4: A write to 0x808 sets `disk_light` to data bit 0.
- R5: A write to 0x81C stores data bits 3:0. A read of 0x81C returns them with bits 7:4 zero.
- R6: A write to 0x850 stores data bit 0 as `map_noncontig` (0 contiguous, 1 non-contiguous). A read of 0x850 returns 0x00 or 0x01.
- R7: A write to 0x810 raises `lock_tog_a` and a write to 0x812 raises `lock_tog_b`, each for one cycle. At most one strobe is high in any cycle.
- R8: Reads return fixed bytes: 0x800 gives 0xEF, 0x802 gives 0xAD, 0x803 gives 0xE0, 0x80C gives 0x3C, 0x810 gives 0x39, 0x818 gives 0x00 and 0x823 gives 0x03.
- R9: A read of any other port returns 0xFF. This includes 0x808, 0x812, 0x814 and ports just outside the scratch pair.
- R10: Writes to 0x800, 0x802 and 0x803 change no output and no read value.
- R11: Ports 0x398 and 0x399 each return the last byte written to them, independently of each other.
- R12: A write to 0x814 raises `cache_inval` for one cycle.
- R13: `port_rdata` is updated on the clock edge that samples `port_rd` and holds its value through cycles without a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| port_addr | input | 16 | Port address |
| port_wdata | input | 8 | Write data |
| port_wr | input | 1 | Write strobe, one cycle per access |
| port_rd | input | 1 | Read strobe, one cycle per access |
| port_rdata | output | 8 | Registered read data |
| endian_le | output | 1 | Little-endian mode |
| map_noncontig | output | 1 | I/O map type, 1 = non-contiguous |
| disk_light | output | 1 | Disk activity light |
| soft_rst_req | output | 1 | Soft-reset request pulse |
| lock_tog_a | output | 1 | NVRAM lock toggle 1 pulse |
| lock_tog_b | output | 1 | NVRAM lock toggle 2 pulse |
| cache_inval | output | 1 | Cache-invalidate pulse |

## Verification
The bench builds the block with its defaults: a 16-bit address, 8-bit data, a 4-bit control field and two scratch bytes based at 0x398. With these values every fixed port and both scratch cells can be reached. Neighbouring addresses such as 0x397, 0x39A and 0x801 test the edges of the decode. The narrow control field lets a write with high bits set show that those bits are dropped.

// File: rtl/sysport_pkg.sv
package sysport_pkg;

  localparam logic [15:0] A_SPECIAL  = 16'h0092;
  localparam logic [15:0] A_ID_CPU   = 16'h0800;
  localparam logic [15:0] A_ID_FEAT  = 16'h0802;
  localparam logic [15:0] A_ID_STAT  = 16'h0803;
  localparam logic [15:0] A_LIGHT    = 16'h0808;
  localparam logic [15:0] A_EQUIP    = 16'h080C;
  localparam logic [15:0] A_LOCK_A   = 16'h0810;
  localparam logic [15:0] A_LOCK_B   = 16'h0812;
  localparam logic [15:0] A_INVAL    = 16'h0814;
  localparam logic [15:0] A_KEY      = 16'h0818;
  localparam logic [15:0] A_CTL      = 16'h081C;
  localparam logic [15:0] A_L2       = 16'h0823;
  localparam logic [15:0] A_MAP      = 16'h0850;

  localparam logic [7:0] V_ID_CPU  = 8'hEF;
  localparam logic [7:0] V_ID_FEAT = 8'hAD;
  localparam logic [7:0] V_ID_STAT = 8'hE0;
  localparam logic [7:0] V_EQUIP   = 8'h3C;
  localparam logic [7:0] V_EXTFEAT = 8'h39;
  localparam logic [7:0] V_KEY     = 8'h00;
  localparam logic [7:0] V_L2      = 8'h03;
  localparam logic [7:0] V_UNMAP   = 8'hFF;

  typedef enum logic [3:0] {
    PK_NONE, PK_SPECIAL, PK_ID_CPU, PK_ID_FEAT, PK_ID_STAT, PK_LIGHT,
    PK_EQUIP, PK_LOCK_A, PK_LOCK_B, PK_INVAL, PK_KEY, PK_CTL, PK_L2,
    PK_MAP, PK_SCRATCH
  } port_kind_e;

endpackage

// File: rtl/sysport_decode.sv
module sysport_decode
  import sysport_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int SCR_N    = 2,
  parameter int SCR_BASE = 16'h0398,
  localparam int SCR_IW  = (SCR_N > 1) ? $clog2(SCR_N) : 1
) (
  input  logic [ADDR_W-1:0] addr,
  output port_kind_e        kind,
  output logic [SCR_IW-1:0] scr_idx
);

  logic [ADDR_W-1:0] scr_off;

  always_comb begin
    scr_off = addr - ADDR_W'(SCR_BASE);
    scr_idx = scr_off[SCR_IW-1:0];
    kind    = PK_NONE;
    if (scr_off < ADDR_W'(SCR_N))        kind = PK_SCRATCH;
    else if (addr == ADDR_W'(A_SPECIAL)) kind = PK_SPECIAL;
    else if (addr == ADDR_W'(A_ID_CPU))  kind = PK_ID_CPU;
    else if (addr == ADDR_W'(A_ID_FEAT)) kind = PK_ID_FEAT;
    else if (addr == ADDR_W'(A_ID_STAT)) kind = PK_ID_STAT;
    else if (addr == ADDR_W'(A_LIGHT))   kind = PK_LIGHT;
    else if (addr == ADDR_W'(A_EQUIP))   kind = PK_EQUIP;
    else if (addr == ADDR_W'(A_LOCK_A))  kind = PK_LOCK_A;
    else if (addr == ADDR_W'(A_LOCK_B))  kind = PK_LOCK_B;
    else if (addr == ADDR_W'(A_INVAL))   kind = PK_INVAL;
    else if (addr == ADDR_W'(A_KEY))     kind = PK_KEY;
    else if (addr == ADDR_W'(A_CTL))     kind = PK_CTL;
    else if (addr == ADDR_W'(A_L2))      kind = PK_L2;
    else if (addr == ADDR_W'(A_MAP))     kind = PK_MAP;
  end

endmodule

// File: rtl/sysport_ctrl.sv
module sysport_ctrl
  import sysport_pkg::*;
#(
  parameter int CTL_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  port_kind_e       kind,
  input  logic [CTL_W-1:0] wbits,
  output logic             endian_le,
  output logic             map_noncontig,
  output logic             disk_light,
  output logic [CTL_W-1:0] ctl_val,
  output logic             soft_rst_req,
  output logic             lock_tog_a,
  output logic             lock_tog_b,
  output logic             cache_inval
);

  always_ff @(posedge clk) begin
    if (rst) begin
      endian_le     <= 1'b0;
      map_noncontig <= 1'b0;
      disk_light    <= 1'b0;
      ctl_val       <= '0;
      soft_rst_req  <= 1'b0;
      lock_tog_a    <= 1'b0;
      lock_tog_b    <= 1'b0;
      cache_inval   <= 1'b0;
    end else begin
      soft_rst_req <= 1'b0;
      lock_tog_a   <= 1'b0;
      lock_tog_b   <= 1'b0;
      cache_inval  <= 1'b0;
      if (wr_en) begin
        case (kind)
          PK_SPECIAL: begin
            endian_le    <= wbits[1];
            soft_rst_req <= wbits[0];
          end
          PK_LIGHT:  disk_light    <= wbits[0];
          PK_CTL:    ctl_val       <= wbits;
          PK_MAP:    map_noncontig <= wbits[0];
          PK_LOCK_A: lock_tog_a    <= 1'b1;
          PK_LOCK_B: lock_tog_b    <= 1'b1;
          PK_INVAL:  cache_inval   <= 1'b1;
          default:   ;
        endcase
      end
    end
  end

  // R7
  strobes_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({soft_rst_req, lock_tog_a, lock_tog_b, cache_inval}));

  // R2
  endian_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(endian_le));

  // R6
  map_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(map_noncontig));

endmodule

// File: rtl/sysport_scratch.sv
module sysport_scratch #(
  parameter int DATA_W = 8,
  parameter int SCR_N  = 2,
  localparam int SCR_IW = (SCR_N > 1) ? $clog2(SCR_N) : 1
) (
  input  logic              clk,
  input  logic              we,
  input  logic [SCR_IW-1:0] idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] cells [SCR_N];

  always_ff @(posedge clk) begin
    if (we) cells[idx] <= wdata;
  end

  assign rdata = cells[idx];

endmodule

// File: rtl/sysport_regs.sv
module sysport_regs
  import sysport_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 8,
  parameter int CTL_W    = 4,
  parameter int SCR_N    = 2,
  parameter int SCR_BASE = 16'h0398
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] port_addr,
  input  logic [DATA_W-1:0] port_wdata,
  input  logic              port_wr,
  input  logic              port_rd,
  output logic [DATA_W-1:0] port_rdata,
  output logic              endian_le,
  output logic              map_noncontig,
  output logic              disk_light,
  output logic              soft_rst_req,
  output logic              lock_tog_a,
  output logic              lock_tog_b,
  output logic              cache_inval
);

  localparam int SCR_IW = (SCR_N > 1) ? $clog2(SCR_N) : 1;

  port_kind_e        kind;
  logic [SCR_IW-1:0] scr_idx;
  logic [CTL_W-1:0]  ctl_val;
  logic [DATA_W-1:0] scr_rdata;
  logic [DATA_W-1:0] rd_next;

  sysport_decode #(.ADDR_W(ADDR_W), .SCR_N(SCR_N), .SCR_BASE(SCR_BASE)) u_dec (
    .addr(port_addr), .kind(kind), .scr_idx(scr_idx)
  );

  sysport_ctrl #(.CTL_W(CTL_W)) u_ctrl (
    .clk(clk), .rst(rst), .wr_en(port_wr), .kind(kind),
    .wbits(port_wdata[CTL_W-1:0]),
    .endian_le(endian_le), .map_noncontig(map_noncontig),
    .disk_light(disk_light), .ctl_val(ctl_val),
    .soft_rst_req(soft_rst_req), .lock_tog_a(lock_tog_a),
    .lock_tog_b(lock_tog_b), .cache_inval(cache_inval)
  );

  sysport_scratch #(.DATA_W(DATA_W), .SCR_N(SCR_N)) u_scr (
    .clk(clk), .we(port_wr && (kind == PK_SCRATCH)), .idx(scr_idx),
    .wdata(port_wdata), .rdata(scr_rdata)
  );

  always_comb begin
    case (kind)
      PK_SPECIAL: rd_next = '0;
      PK_ID_CPU:  rd_next = DATA_W'(V_ID_CPU);
      PK_ID_FEAT: rd_next = DATA_W'(V_ID_FEAT);
      PK_ID_STAT: rd_next = DATA_W'(V_ID_STAT);
      PK_EQUIP:   rd_next = DATA_W'(V_EQUIP);
      PK_LOCK_A:  rd_next = DATA_W'(V_EXTFEAT);
      PK_KEY:     rd_next = DATA_W'(V_KEY);
      PK_L2:      rd_next = DATA_W'(V_L2);
      PK_CTL:     rd_next = DATA_W'(ctl_val);
      PK_MAP:     rd_next = DATA_W'(map_noncontig);
      PK_SCRATCH: rd_next = scr_rdata;
      default:    rd_next = DATA_W'(V_UNMAP);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)          port_rdata <= '0;
    else if (port_rd) port_rdata <= rd_next;
  end

  // R5
  ctl_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (port_rd && port_addr == ADDR_W'(A_CTL)) |=> (port_rdata[DATA_W-1:CTL_W] == '0));

  // R9
  unmapped_ff_chk: assert property (@(posedge clk) disable iff (rst)
    (port_rd && kind == PK_NONE) |=> (port_rdata == DATA_W'(V_UNMAP)));

  // R8
  cpu_id_chk: assert property (@(posedge clk) disable iff (rst)
    (port_rd && port_addr == ADDR_W'(A_ID_CPU)) |=> (port_rdata == DATA_W'(V_ID_CPU)));

  // R13
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !port_rd |=> $stable(port_rdata));

endmodule

// File: tb/sysport_regs_tb.sv
module sysport_regs_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] port_addr = '0;
  logic [7:0]  port_wdata = '0;
  logic        port_wr = 1'b0;
  logic        port_rd = 1'b0;
  logic [7:0]  port_rdata;
  logic        endian_le, map_noncontig, disk_light;
  logic        soft_rst_req, lock_tog_a, lock_tog_b, cache_inval;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  sysport_regs dut_i (
    .clk(clk), .rst(rst), .port_addr(port_addr), .port_wdata(port_wdata),
    .port_wr(port_wr), .port_rd(port_rd), .port_rdata(port_rdata),
    .endian_le(endian_le), .map_noncontig(map_noncontig),
    .disk_light(disk_light), .soft_rst_req(soft_rst_req),
    .lock_tog_a(lock_tog_a), .lock_tog_b(lock_tog_b),
    .cache_inval(cache_inval)
  );

  // Behavioural reference model
  bit        m_end, m_map, m_light, m_soft, m_la, m_lb, m_inv;
  bit [3:0]  m_ctl;
  bit [7:0]  m_rd;
  bit [7:0]  m_scr [int];

  function automatic bit [7:0] model_read(input int a);
    case (a)
      'h092: return 8'h00;
      'h800: return 8'hEF;
      'h802: return 8'hAD;
      'h803: return 8'hE0;
      'h80C: return 8'h3C;
      'h810: return 8'h39;
      'h818: return 8'h00;
      'h823: return 8'h03;
      'h81C: return {4'h0, m_ctl};
      'h850: return {7'h0, m_map};
      'h398, 'h399: return m_scr.exists(a) ? m_scr[a] : 8'h00;
      default: return 8'hFF;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_end = 0; m_map = 0; m_light = 0; m_ctl = 0; m_rd = 0;
      m_soft = 0; m_la = 0; m_lb = 0; m_inv = 0;
    end else begin
      int a;
      a = int'(port_addr);
      m_soft = 0; m_la = 0; m_lb = 0; m_inv = 0;
      if (port_rd) m_rd = model_read(a);
      if (port_wr) begin
        case (a)
          'h092: begin m_end = port_wdata[1]; m_soft = port_wdata[0]; end
          'h808: m_light = port_wdata[0];
          'h81C: m_ctl = port_wdata[3:0];
          'h850: m_map = port_wdata[0];
          'h810: m_la = 1;
          'h812: m_lb = 1;
          'h814: m_inv = 1;
          'h398, 'h399: m_scr[a] = port_wdata;
          default: ;
        endcase
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Compare against the model on every clock, away from the edge
  always @(posedge clk) begin
    #2;
    if (!rst) begin
      chk("MODEL rdata", {24'h0, port_rdata}, {24'h0, m_rd});
      chk("MODEL outputs",
          {25'h0, endian_le, map_noncontig, disk_light, soft_rst_req, lock_tog_a, lock_tog_b, cache_inval},
          {25'h0, m_end, m_map, m_light, m_soft, m_la, m_lb, m_inv});
    end
  end

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    port_addr = a; port_wdata = d; port_wr = 1'b1;
    @(negedge clk);
    port_wr = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a);
    @(negedge clk);
    port_addr = a; port_rd = 1'b1;
    @(negedge clk);
    port_rd = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [15:0] a, input logic [7:0] exp);
    rd(a);
    chk(req, {24'h0, port_rdata}, {24'h0, exp});
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 outputs after reset",
        {25'h0, endian_le, map_noncontig, disk_light, soft_rst_req, lock_tog_a, lock_tog_b, cache_inval}, 32'h0);
    chk("R1 rdata after reset", {24'h0, port_rdata}, 32'h0);
    rd_chk("R1 control value after reset", 16'h081C, 8'h00);

    // R2 endian mode
    wr(16'h0092, 8'h02);
    chk("R2 endian set", {31'h0, endian_le}, 32'h1);
    chk("R3 no soft reset when bit0 clear", {31'h0, soft_rst_req}, 32'h0);
    rd_chk("R2 read of 0x092", 16'h0092, 8'h00);
    repeat (3) @(negedge clk);
    chk("R2 endian holds", {31'h0, endian_le}, 32'h1);
    wr(16'h0092, 8'h00);
    chk("R2 endian cleared", {31'h0, endian_le}, 32'h0);

    // R3 soft-reset pulse
    wr(16'h0092, 8'h01);
    chk("R3 soft reset high", {31'h0, soft_rst_req}, 32'h1);
    @(negedge clk);
    chk("R3 soft reset one cycle", {31'h0, soft_rst_req}, 32'h0);

    // R4 disk light
    wr(16'h0808, 8'h01);
    chk("R4 light on", {31'h0, disk_light}, 32'h1);
    wr(16'h0808, 8'hFE);
    chk("R4 light off", {31'h0, disk_light}, 32'h0);

    // R5 control nibble
    wr(16'h081C, 8'hA7);
    rd_chk("R5 control low nibble", 16'h081C, 8'h07);
    wr(16'h081C, 8'h3C);
    rd_chk("R5 control update", 16'h081C, 8'h0C);

    // R6 map type
    wr(16'h0850, 8'hFF);
    chk("R6 map non-contiguous", {31'h0, map_noncontig}, 32'h1);
    rd_chk("R6 map read 1", 16'h0850, 8'h01);
    wr(16'h0850, 8'h02);
    chk("R6 map contiguous", {31'h0, map_noncontig}, 32'h0);
    rd_chk("R6 map read 0", 16'h0850, 8'h00);

    // R7 lock toggles
    wr(16'h0810, 8'h00);
    chk("R7 lock a pulse", {30'h0, lock_tog_a, lock_tog_b}, 32'h2);
    @(negedge clk);
    chk("R7 lock a one cycle", {31'h0, lock_tog_a}, 32'h0);
    wr(16'h0812, 8'h55);
    chk("R7 lock b pulse", {30'h0, lock_tog_a, lock_tog_b}, 32'h1);
    @(negedge clk);
    chk("R7 lock b one cycle", {31'h0, lock_tog_b}, 32'h0);

    // R8 fixed bytes
    rd_chk("R8 0x800", 16'h0800, 8'hEF);
    rd_chk("R8 0x802", 16'h0802, 8'hAD);
    rd_chk("R8 0x803", 16'h0803, 8'hE0);
    rd_chk("R8 0x80C", 16'h080C, 8'h3C);
    rd_chk("R8 0x810", 16'h0810, 8'h39);
    rd_chk("R8 0x818", 16'h0818, 8'h00);
    rd_chk("R8 0x823", 16'h0823, 8'h03);

    // R9 unmapped reads
    rd_chk("R9 0x814", 16'h0814, 8'hFF);
    rd_chk("R9 0x808", 16'h0808, 8'hFF);
    rd_chk("R9 0x812", 16'h0812, 8'hFF);
    rd_chk("R9 0x801", 16'h0801, 8'hFF);
    rd_chk("R9 0x397", 16'h0397, 8'hFF);
    rd_chk("R9 0x39A", 16'h039A, 8'hFF);

    // R10 read-only ports ignore writes
    wr(16'h0092, 8'h02);
    wr(16'h0850, 8'h01);
    wr(16'h0800, 8'h00);
    wr(16'h0802, 8'h00);
    wr(16'h0803, 8'hFF);
    chk("R10 outputs unchanged",
        {25'h0, endian_le, map_noncontig, disk_light, soft_rst_req, lock_tog_a, lock_tog_b, cache_inval},
        {25'h0, 1'b1, 1'b1, 5'b00000});
    rd_chk("R10 0x800 still fixed", 16'h0800, 8'hEF);
    rd_chk("R10 0x802 still fixed", 16'h0802, 8'hAD);
    rd_chk("R10 0x803 still fixed", 16'h0803, 8'hE0);
    rd_chk("R10 control untouched", 16'h081C, 8'h0C);

    // R11 scratch pair
    wr(16'h0398, 8'h5A);
    wr(16'h0399, 8'hC3);
    rd_chk("R11 scratch 0", 16'h0398, 8'h5A);
    rd_chk("R11 scratch 1", 16'h0399, 8'hC3);
    wr(16'h0398, 8'h81);
    rd_chk("R11 scratch 0 rewrite", 16'h0398, 8'h81);
    rd_chk("R11 scratch 1 independent", 16'h0399, 8'hC3);

    // R12 cache invalidate
    wr(16'h0814, 8'h00);
    chk("R12 invalidate pulse", {31'h0, cache_inval}, 32'h1);
    @(negedge clk);
    chk("R12 invalidate one cycle", {31'h0, cache_inval}, 32'h0);

    // R13 read data holds
    rd(16'h0800);
    wr(16'h081C, 8'h05);
    repeat (2) @(negedge clk);
    chk("R13 rdata holds", {24'h0, port_rdata}, 32'hEF);

    repeat (2) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule